// File: doc/BRIEF.md
# Auto-Reload Variable-Length PWM Channel

This block is a single compare channel of a counter array, fixed to a pulse width modulation mode whose cycle length is 9, 10 or 11 bits. It watches a shared free-running timebase count, qualified by a one-cycle count-enable strobe. The output pin rises when the low N bits of the count equal the channel's compare value. It falls when those N bits wrap to zero, which marks the Nth-bit overflow. On each wrap a shadow auto-reload value is copied into the live compare register, so software can set the next duty cycle at any time without glitching the current period.

Software reaches the block through a byte-wide register port with four addresses. Two of them are dual-mapped compare bytes. An access-select bit steers them to the reload register or to the live compare register. Writing the low compare byte clears the comparator enable and writing the high byte sets it. A 0% duty cycle therefore comes from writing only the low byte, not from a special compare value. Sticky match and overflow flags record events until software writes a 0 to them.

Top module: `pwm_ar_chan`

## Requirements
- R1: After reset the output is low, and every register reads back as 0x00 (both compare bytes, the reload bytes, the channel mode byte and the array control byte).
- R2: The array control byte (address 3) holds the length code in bits [1:0]: 01 gives N=9, 10 gives N=10 and 11 gives N=11. The block is active only when the code is non-zero and the channel-on bit (bit 1 of address 2) is 1. While inactive the output is low and no flag is set.
- R3: With the comparator enable (bit 0 of address 2) set, an enabled cycle whose count has its low N bits equal to the compare value's low N bits drives the output high from the next cycle. For a compare value C between 1 and 2^N-1, this gives 2^N-C high cycles per period of 2^N enabled counts.
- R4: An enabled cycle whose count has its low N bits all zero drives the output low from the next cycle. The same cycle sets the overflow flag (bit 3 of address 3) and copies the full 16-bit reload register into the compare register.
- R5: The access-select bit (bit 2 of address 3) routes reads and writes of address 0 (low byte) and address 1 (high byte). A 1 routes them to the reload register and a 0 routes them to the compare register.
- R6: Any write to address 0 clears the comparator enable, and any write to address 1 sets it. While the comparator enable is clear, the output never goes high.
- R7: When the match-flag enable (bit 2 of address 2) is set, every compare match that drives the output sets the match flag (bit 3 of address 2).
- R8: Bits above N-1 of the count and of the compare value take no part in the comparison. The reload and compare registers read back all 16 stored bits.
- R9: Cycles with the count-enable strobe low cause no match, no wrap, no output change and no flag change.
- R10: Each flag stays set until software writes a 0 to its bit. Writing a 1 to a flag bit leaves it unchanged.
- R11: If a match and a wrap fall in the same enabled cycle, the output ends that cycle low and the match flag is still set.
- R12: A read strobe at address A presents the byte on the read data port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 16 | Shared timebase count value |
| cnt_en | input | 1 | One-cycle strobe marking a valid count step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 low byte, 1 high byte, 2 channel mode, 3 array control) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| pwm_out | output | 1 | Channel output pin |

## Verification
The assertions assume that only one register access occurs per cycle and that the timebase advances by exactly one on each strobe. They also assume that flag clears never land in the same cycle as the event that sets the flag. The stimulus steps the count one value per enabled cycle, never issues overlapping reads and writes, and clears flags only while the strobe is idle. Count steps cross both the 9-bit and the 10-bit wrap points with matching upper-bit patterns, so that a wrong mask width would show up at the output pin.

// File: rtl/pwm_ar_pkg.sv
package pwm_ar_pkg;

  typedef enum logic [1:0] {
    A_CMP_LO = 2'd0,
    A_CMP_HI = 2'd1,
    A_CHAN   = 2'd2,
    A_ARRAY  = 2'd3
  } reg_addr_e;

  // channel mode byte
  localparam int B_CMP_EN = 0;
  localparam int B_PWM_ON = 1;
  localparam int B_MF_EN  = 2;
  localparam int B_MFLAG  = 3;

  // array control byte
  localparam int B_LEN_LO = 0;
  localparam int B_SEL    = 2;
  localparam int B_OFLAG  = 3;

endpackage

// File: rtl/pwm_ar_detect.sv
module pwm_ar_detect #(
  parameter int CNT_W     = 16,
  parameter int BASE_BITS = 8
) (
  input  logic [CNT_W-1:0] tb_count,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             cmp_en,
  input  logic             pwm_on,
  input  logic [1:0]       len_sel,
  output logic             active,
  output logic             ovf_evt,
  output logic             hit_evt
);
  localparam int NSEL = 4;

  logic [CNT_W-1:0] mask_tbl [NSEL];
  logic [CNT_W-1:0] mask;

  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_mask
      assign mask_tbl[g] = CNT_W'((64'd1 << (BASE_BITS + g)) - 64'd1);
    end
  endgenerate

  assign mask    = mask_tbl[len_sel];
  assign active  = pwm_on && (len_sel != 2'd0);
  assign ovf_evt = active && cnt_en && ((tb_count & mask) == '0);
  assign hit_evt = active && cnt_en && cmp_en &&
                   (((tb_count ^ cmp_q) & mask) == '0);

endmodule

// File: rtl/pwm_ar_regs.sv
module pwm_ar_regs
  import pwm_ar_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_evt,
  input  logic              hit_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              cmp_en,
  output logic              pwm_on,
  output logic [1:0]        len_sel
);
  reg_addr_e         a;
  logic [CNT_W-1:0]  rld_q;
  logic              mf_en, mflag, rld_sel, oflag;
  logic [DATA_W-1:0] rd_next;
  logic              wr_lo, wr_hi, wr_chan, wr_array;

  assign a        = reg_addr_e'(addr);
  assign wr_lo    = wr_en && (a == A_CMP_LO);
  assign wr_hi    = wr_en && (a == A_CMP_HI);
  assign wr_chan  = wr_en && (a == A_CHAN);
  assign wr_array = wr_en && (a == A_ARRAY);

  // reload shadow register
  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
    end else if (rld_sel) begin
      if (wr_lo) rld_q[DATA_W-1:0]     <= wr_data;
      if (wr_hi) rld_q[CNT_W-1:DATA_W] <= wr_data;
    end
  end

  // live compare register: the wrap copy takes priority over software
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (ovf_evt) begin
      cmp_q <= rld_q;
    end else if (!rld_sel) begin
      if (wr_lo) cmp_q[DATA_W-1:0]     <= wr_data;
      if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wr_data;
    end
  end

  // channel mode byte
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_en <= 1'b0;
      pwm_on <= 1'b0;
      mf_en  <= 1'b0;
      mflag  <= 1'b0;
    end else begin
      if (wr_lo)      cmp_en <= 1'b0;
      else if (wr_hi) cmp_en <= 1'b1;
      else if (wr_chan) cmp_en <= wr_data[B_CMP_EN];
      if (wr_chan) begin
        pwm_on <= wr_data[B_PWM_ON];
        mf_en  <= wr_data[B_MF_EN];
      end
      if (hit_evt && mf_en)                 mflag <= 1'b1;
      else if (wr_chan && !wr_data[B_MFLAG]) mflag <= 1'b0;
    end
  end

  // array control byte
  always_ff @(posedge clk) begin
    if (rst) begin
      len_sel <= 2'd0;
      rld_sel <= 1'b0;
      oflag   <= 1'b0;
    end else begin
      if (wr_array) begin
        len_sel <= wr_data[B_LEN_LO+1:B_LEN_LO];
        rld_sel <= wr_data[B_SEL];
      end
      if (ovf_evt)                            oflag <= 1'b1;
      else if (wr_array && !wr_data[B_OFLAG]) oflag <= 1'b0;
    end
  end

  // read path, registered
  always_comb begin
    rd_next = '0;
    case (a)
      A_CMP_LO: rd_next = rld_sel ? rld_q[DATA_W-1:0] : cmp_q[DATA_W-1:0];
      A_CMP_HI: rd_next = rld_sel ? rld_q[CNT_W-1:DATA_W] : cmp_q[CNT_W-1:DATA_W];
      A_CHAN: begin
        rd_next[B_CMP_EN] = cmp_en;
        rd_next[B_PWM_ON] = pwm_on;
        rd_next[B_MF_EN]  = mf_en;
        rd_next[B_MFLAG]  = mflag;
      end
      A_ARRAY: begin
        rd_next[B_LEN_LO+1:B_LEN_LO] = len_sel;
        rd_next[B_SEL]               = rld_sel;
        rd_next[B_OFLAG]             = oflag;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  p_lo_clears_en_r6: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> !cmp_en);
  p_hi_sets_en_r6: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> cmp_en);
  p_reload_copy_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (cmp_q == $past(rld_q)));
  p_oflag_set_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> oflag);
  p_oflag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (oflag && !(wr_array && !wr_data[B_OFLAG])) |=> oflag);
  p_mflag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (mflag && !(wr_chan && !wr_data[B_MFLAG])) |=> mflag);

endmodule

// File: rtl/pwm_ar_pin.sv
module pwm_ar_pin (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ovf_evt,
  input  logic hit_evt,
  output logic pwm_out
);

  always_ff @(posedge clk) begin
    if (rst)                      pwm_out <= 1'b0;
    else if (!active || ovf_evt)  pwm_out <= 1'b0;
    else if (hit_evt)             pwm_out <= 1'b1;
  end

  p_fall_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> !pwm_out);
  p_rise_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_evt && !ovf_evt) |=> pwm_out);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwm_out);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (active && !ovf_evt && !hit_evt) |=> $stable(pwm_out));

endmodule

// File: rtl/pwm_ar_chan.sv
module pwm_ar_chan #(
  parameter int CNT_W     = 16,
  parameter int BASE_BITS = 8,
  parameter int DATA_W    = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tb_count,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  logic [CNT_W-1:0] cmp_q;
  logic             cmp_en, pwm_on, active, ovf_evt, hit_evt;
  logic [1:0]       len_sel;

  pwm_ar_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .ovf_evt (ovf_evt),
    .hit_evt (hit_evt),
    .rd_data (rd_data),
    .cmp_q   (cmp_q),
    .cmp_en  (cmp_en),
    .pwm_on  (pwm_on),
    .len_sel (len_sel)
  );

  pwm_ar_detect #(.CNT_W(CNT_W), .BASE_BITS(BASE_BITS)) u_detect (
    .tb_count (tb_count),
    .cnt_en   (cnt_en),
    .cmp_q    (cmp_q),
    .cmp_en   (cmp_en),
    .pwm_on   (pwm_on),
    .len_sel  (len_sel),
    .active   (active),
    .ovf_evt  (ovf_evt),
    .hit_evt  (hit_evt)
  );

  pwm_ar_pin u_pin (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .ovf_evt (ovf_evt),
    .hit_evt (hit_evt),
    .pwm_out (pwm_out)
  );

  p_no_event_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(pwm_out) || !$past(active));

endmodule

// File: tb/pwm_ar_chan_test.sv
`timescale 1ns/1ps
module pwm_ar_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tb_count = '0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;
  int hi;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    logic [1:0] a;
    string      req;
  } rd_item_t;
  rd_item_t sb_q[$];
  rd_item_t item;
  logic     rd_fire = 1'b0;

  always #4 clk = ~clk;

  pwm_ar_chan uut (
    .clk(clk), .rst(rst), .tb_count(tb_count), .cnt_en(cnt_en),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always @(posedge clk) rd_fire <= rd_en;

  // monitor: compares each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_fire) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL %s: read with no expected item, got %h", "R12", rd_data);
      end else begin
        item = sb_q.pop_front();
        if (rd_data !== item.exp) begin
          errors++;
          $display("FAIL %s: addr %0d read %h expected %h", item.req, item.a, rd_data, item.exp);
        end
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
    rd_item_t it;
    it.exp = e; it.a = a; it.req = req;
    sb_q.push_back(it);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic tick(input int v, input logic en);
    tb_count = v[15:0]; cnt_en = en;
    @(posedge clk); #1;
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 out after reset", pwm_out, 0);
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h00, "R1");

    // reload access, 9-bit length
    wr(3, 8'h05);
    wr(0, 8'h64);
    rd(2, 8'h00, "R6 low write clears enable");
    wr(1, 8'hFE);
    rd(2, 8'h01, "R6 high write sets enable");
    rd(0, 8'h64, "R5 reload low");
    rd(1, 8'hFE, "R8 reload high stored bits");
    wr(3, 8'h01);
    rd(0, 8'h00, "R5 compare low untouched");
    rd(1, 8'h00, "R5 compare high untouched");
    wr(2, 8'h07);

    // compare 0 and wrap coincide at count 0
    tick(0, 1'b1);
    chk("R11 coincident low", pwm_out, 0);
    rd(2, 8'h0F, "R11 match flag set");
    rd(3, 8'h09, "R4 overflow flag");
    rd(0, 8'h64, "R4 copy low");
    rd(1, 8'hFE, "R4 copy high");

    wr(2, 8'h07); wr(3, 8'h01);
    rd(2, 8'h07, "R10 match flag cleared");
    rd(3, 8'h01, "R10 overflow flag cleared");
    wr(2, 8'h0F);
    rd(2, 8'h07, "R10 write one no effect");

    for (int v = 1; v < 100; v++) tick(v, 1'b1);
    chk("R3 low before match", pwm_out, 0);
    rd(2, 8'h07, "R7 no flag before match");

    tick(100, 1'b0); tick(100, 1'b0);
    chk("R9 no strobe no rise", pwm_out, 0);
    rd(2, 8'h07, "R9 no flag without strobe");

    hi = 0;
    for (int v = 100; v < 512; v++) begin
      tick(v, 1'b1);
      if (v == 100) chk("R3 rise at match", pwm_out, 1);
      if (pwm_out) hi++;
    end
    chk("R3 high cycles 9-bit", hi, 412);
    rd(2, 8'h0F, "R7 match flag");
    tick(512, 1'b1);
    chk("R4 fall at wrap", pwm_out, 0);

    for (int v = 513; v < 612; v++) tick(v, 1'b1);
    chk("R8 low before masked match", pwm_out, 0);
    tick(612, 1'b1);
    chk("R8 upper bits ignored", pwm_out, 1);

    // 10-bit length; compare low 10 bits now 0x264
    wr(3, 8'h02);
    for (int v = 613; v < 1024; v++) tick(v, 1'b1);
    chk("R2 still high before 10-bit wrap", pwm_out, 1);
    tick(1024, 1'b1);
    chk("R2 fall at 10-bit wrap", pwm_out, 0);
    for (int v = 1025; v < 1636; v++) begin
      tick(v, 1'b1);
      if (v == 1124) chk("R2 no 9-bit match", pwm_out, 0);
    end
    hi = 0;
    for (int v = 1636; v < 2048; v++) begin
      tick(v, 1'b1);
      if (pwm_out) hi++;
    end
    chk("R2 high cycles 10-bit", hi, 412);
    tick(2048, 1'b1);
    chk("R2 fall at 2048", pwm_out, 0);
    rd(3, 8'h0A, "R10 overflow flag sticky");

    // length code 00: inactive
    wr(2, 8'h07);
    wr(3, 8'h00);
    hi = 0;
    for (int v = 2049; v < 2700; v++) begin
      tick(v, 1'b1);
      if (pwm_out) hi++;
    end
    chk("R2 idle output", hi, 0);
    rd(3, 8'h00, "R2 idle no overflow flag");
    rd(2, 8'h07, "R2 idle no match flag");

    // 0% duty through a low-byte write
    wr(3, 8'h01);
    wr(0, 8'h64);
    rd(2, 8'h06, "R6 enable cleared");
    hi = 0;
    for (int v = 2700; v < 3800; v++) begin
      tick(v, 1'b1);
      if (pwm_out) hi++;
    end
    chk("R6 zero duty", hi, 0);
    rd(2, 8'h06, "R7 no flag while disabled");

    repeat (3) @(posedge clk);
    #1 chk("R12 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule